// File: doc/BRIEF.md
# Active Power Averager with Offset

This block turns a stream of signed instantaneous power samples into an active power figure. Each accepted sample has a programmable signed offset added to it, and the corrected values are summed over a computation cycle of N accepted samples. When the cycle closes, the sum is divided by the number of samples it holds. The quotient is rounded toward negative infinity, clamped to the 1.23 range and published with a one-clock done strobe. An out-of-range flag accompanies each result.

Samples, the offset and the result all use two's complement 1.23 format, which covers -1.0 up to just under +1.0. The accumulator is sized so that an intermediate sum never wraps. Division runs serially, one quotient bit per clock, while the accumulator has already been cleared and is collecting the next cycle.

Because of this, two consecutive cycle closes must be at least ACC_W+2 clocks apart, where ACC_W = DATA_W + CNT_W + 2. Meter-class conversion rates are far below the logic clock, so this is easy to meet.

Top module: `activePowerAvg`

## Requirements
- R1: While rstN is low and after its release, activePower is 0, overflow is 0 and cycleDone is 0. The offset register also resets to 0, so a single sample s with N=1 and no offset load yields s.
- R2: When offLoad is high at a clock edge, offValue (signed 1.23) is captured as the offset. The new offset applies to samples accepted at later edges. A sample accepted at the same edge as the load uses the previous offset.
- R3: A computation cycle closes on the Nth accepted sample, where N is cycleCount (unsigned) and a cycleCount of 0 acts as 1. The next accepted sample starts a new cycle.
- R4: For a cycle that is not saturated, the result is floor(sum over the cycle of (sample + offset) / N), given in signed 1.23 on activePower.
- R5: If that quotient is above 0x7FFFFF, activePower becomes 0x7FFFFF. If it is below -0x800000, activePower becomes 0x800000. overflow is 1 with a saturated result and 0 with any other result.
- R6: cycleDone is high for exactly one clock, ACC_W+1 clocks after the edge that accepts the closing sample. activePower and overflow change only in that clock and hold their values at all other times.
- R7: No intermediate sum wraps. N = 2^CNT_W-1 samples of the most positive sum (sample 0x7FFFFF with offset 0x7FFFFF) saturate positive. N samples of the most negative sum (0x800000 + 0x800000) saturate negative.
- R8: A negative average that is not exact rounds toward negative infinity. For example, a sum of -1 over N=2 gives 0xFFFFFF, and a sum of -4 over N=3 gives -2.
- R9: The value on sampleData while sampleValid is low has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Qualifies sampleData for one clock |
| sampleData | input | DATA_W | Instantaneous power sample, signed 1.23 |
| offLoad | input | 1 | Writes offValue into the offset register |
| offValue | input | DATA_W | New power offset, signed 1.23 |
| cycleCount | input | CNT_W | Samples per computation cycle, N (0 treated as 1) |
| activePower | output | DATA_W | Averaged active power, signed 1.23 |
| overflow | output | 1 | Result was saturated (energy out of range) |
| cycleDone | output | 1 | One-clock strobe when a new result is published |

## Verification
The embedded assertions check on every clock that the result and flag stay frozen outside the done strobe and that the strobe never lasts two clocks. They also check that a flagged result is one of the two clamp values, that the divider remainder stays below its divisor, and that no cycle closes while a division is still running. Whether the published value equals the floored mean of offset-corrected samples can only be shown by the bench's scenarios. The same holds for the N=0 rule, the timing of a same-edge offset load and rounding of negative averages. The bench sweeps every N of a narrow count configuration over several sample patterns and offsets, and computes each expected mean arithmetically.

// File: rtl/pwrAvgPkg.sv
package pwrAvgPkg;

  // Strobes from the sequencing logic to the arithmetic
  typedef struct packed {
    logic accAdd;      // fold the corrected sample into the running sum
    logic divLoad;     // close the cycle: hand total to divider, clear sum
    logic divStep;     // produce one quotient bit
    logic resultLoad;  // round, clamp and publish
  } avgCtrl_t;

endpackage

// File: rtl/pwrAvgCtrl.sv
module pwrAvgCtrl
  import pwrAvgPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACC_W = 34
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] cycleCount,
  output avgCtrl_t         ctl,
  output logic [CNT_W-1:0] divisor
);

  localparam int STEP_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W:0]    nextCnt;
  logic [CNT_W-1:0]  nEff;
  logic              closeNow;
  logic              busy;
  logic              finPend;
  logic [STEP_W-1:0] stepCnt;

  assign nextCnt  = {1'b0, sampleCnt} + {{CNT_W{1'b0}}, 1'b1};
  assign nEff     = (cycleCount == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cycleCount;
  assign closeNow = sampleValid && (nextCnt >= {1'b0, nEff});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (sampleValid) begin
      sampleCnt <= closeNow ? '0 : nextCnt[CNT_W-1:0];
    end
  end

  // Serial divider sequencing: ACC_W steps, then one publish clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      finPend <= 1'b0;
      stepCnt <= '0;
    end else begin
      finPend <= 1'b0;
      if (closeNow) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == STEP_W'(ACC_W - 1)) begin
          busy    <= 1'b0;
          finPend <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.accAdd     = sampleValid && !closeNow;
    ctl.divLoad    = closeNow;
    ctl.divStep    = busy;
    ctl.resultLoad = finPend;
  end

  assign divisor = nextCnt[CNT_W-1:0];

  // R3: a new cycle may only close once the previous division finished
  p_cycle_spacing_r3 : assert property (@(posedge clk) disable iff (!rstN)
    closeNow |-> !busy);

  // R6: step counter never runs past the divider length
  p_step_bound_r6 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt < STEP_W'(ACC_W)));

  // R6: publish follows the last division step directly
  p_publish_after_div_r6 : assert property (@(posedge clk) disable iff (!rstN)
    finPend |-> !busy);

endmodule

// File: rtl/pwrAvgDatapath.sv
module pwrAvgDatapath
  import pwrAvgPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  avgCtrl_t          ctl,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              offLoad,
  input  logic [DATA_W-1:0] offValue,
  input  logic [CNT_W-1:0]  divisor,
  output logic [DATA_W-1:0] activePower,
  output logic              overflow,
  output logic              cycleDone
);

  localparam int SUM_W = DATA_W + 1;
  localparam int EXT_W = ACC_W - SUM_W;
  localparam int PAD_W = ACC_W - DATA_W + 2;
  localparam logic signed [ACC_W:0]  POS_LIM = {{PAD_W{1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]  NEG_LIM = {{PAD_W{1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0]      OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0]      OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]        offsetReg;
  logic signed [SUM_W-1:0]  sampleSum;
  logic signed [ACC_W-1:0]  accReg;
  logic signed [ACC_W-1:0]  closeTotal;
  logic [ACC_W-1:0]         quoReg;
  logic [CNT_W-1:0]         remReg;
  logic [CNT_W-1:0]         divReg;
  logic                     negFlag;
  logic [CNT_W:0]           remShift;
  logic                     stepGe;
  logic [CNT_W:0]           remNext;
  logic signed [ACC_W:0]    quoWide;
  logic signed [ACC_W:0]    roundAdj;
  logic signed [ACC_W:0]    finalQ;

  // Offset register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) offsetReg <= '0;
    else if (offLoad) offsetReg <= offValue;
  end

  // Offset correction and accumulation
  assign sampleSum  = $signed({sampleData[DATA_W-1], sampleData})
                    + $signed({offsetReg[DATA_W-1], offsetReg});
  assign closeTotal = accReg + $signed({{EXT_W{sampleSum[SUM_W-1]}}, sampleSum});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (ctl.divLoad) begin
      accReg <= '0;
    end else if (ctl.accAdd) begin
      accReg <= closeTotal;
    end
  end

  // Restoring division of the magnitude, one bit per clock
  assign remShift = {remReg, quoReg[ACC_W-1]};
  assign stepGe   = remShift >= {1'b0, divReg};
  assign remNext  = stepGe ? (remShift - {1'b0, divReg}) : remShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg  <= '0;
      remReg  <= '0;
      divReg  <= '0;
      negFlag <= 1'b0;
    end else if (ctl.divLoad) begin
      negFlag <= closeTotal[ACC_W-1];
      quoReg  <= closeTotal[ACC_W-1] ? -closeTotal : closeTotal;
      remReg  <= '0;
      divReg  <= divisor;
    end else if (ctl.divStep) begin
      quoReg  <= {quoReg[ACC_W-2:0], stepGe};
      remReg  <= remNext[CNT_W-1:0];
    end
  end

  // Floor rounding for negative totals, then clamping
  assign quoWide  = $signed({1'b0, quoReg});
  assign roundAdj = $signed({{ACC_W{1'b0}}, (remReg != '0)});
  assign finalQ   = negFlag ? (-quoWide - roundAdj) : quoWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePower <= '0;
      overflow    <= 1'b0;
      cycleDone   <= 1'b0;
    end else begin
      cycleDone <= ctl.resultLoad;
      if (ctl.resultLoad) begin
        if (finalQ > POS_LIM) begin
          activePower <= OUT_MAX;
          overflow    <= 1'b1;
        end else if (finalQ < NEG_LIM) begin
          activePower <= OUT_MIN;
          overflow    <= 1'b1;
        end else begin
          activePower <= finalQ[DATA_W-1:0];
          overflow    <= 1'b0;
        end
      end
    end
  end

  // R6: result and flag frozen between done strobes
  p_result_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !cycleDone |-> ($stable(activePower) && $stable(overflow)));

  // R6: done strobe lasts a single clock
  p_done_pulse_r6 : assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R5: a flagged result is one of the clamp values
  p_no_overflow_r5 : assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (activePower == OUT_MAX || activePower == OUT_MIN));

  // R4: remainder of the serial divider stays below the divisor
  p_div_rem_r4 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.divStep |-> (remReg < divReg));

  // R3: a closing cycle always divides by a nonzero count
  p_div_nonzero_r3 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.divLoad |-> (divisor != '0));

endmodule

// File: rtl/activePowerAvg.sv
module activePowerAvg
  import pwrAvgPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              offLoad,
  input  logic [DATA_W-1:0] offValue,
  input  logic [CNT_W-1:0]  cycleCount,
  output logic [DATA_W-1:0] activePower,
  output logic              overflow,
  output logic              cycleDone
);

  localparam int ACC_W = DATA_W + CNT_W + 2;

  avgCtrl_t         ctl;
  logic [CNT_W-1:0] divisor;

  pwrAvgCtrl #(
    .CNT_W(CNT_W),
    .ACC_W(ACC_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .cycleCount (cycleCount),
    .ctl        (ctl),
    .divisor    (divisor)
  );

  pwrAvgDatapath #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .ACC_W (ACC_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleData (sampleData),
    .offLoad    (offLoad),
    .offValue   (offValue),
    .divisor    (divisor),
    .activePower(activePower),
    .overflow   (overflow),
    .cycleDone  (cycleDone)
  );

endmodule

// File: tb/sim_activePowerAvg.sv
`timescale 1ns/1ps
module sim_activePowerAvg;

  localparam int DW  = 24;
  localparam int CW  = 4;
  localparam int AW  = DW + CW + 2;
  localparam int LAT = AW + 1;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic          offLoad = 1'b0;
  logic [DW-1:0] offValue = '0;
  logic [CW-1:0] cycleCount = '0;
  logic [DW-1:0] activePower;
  logic          overflow;
  logic          cycleDone;

  int      checks = 0;
  int      errors = 0;
  bit      finished = 0;
  longint  offModel = 0;
  logic [DW-1:0] smp [16];
  logic [31:0]   lfsr = 32'h1234_5678;

  activePowerAvg #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .offLoad(offLoad), .offValue(offValue), .cycleCount(cycleCount),
    .activePower(activePower), .overflow(overflow), .cycleDone(cycleDone)
  );

  always #2.5 clk = ~clk;

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadOffset(input logic [DW-1:0] v);
    offLoad = 1'b1; offValue = v;
    @(posedge clk); @(negedge clk);
    offLoad = 1'b0; offValue = 24'h0F0F0F;
    offModel = sx(v);
  endtask

  // Runs one computation cycle; starts and ends at a falling edge.
  // loadAt >= 0 loads newOff together with that sample (R2).
  task automatic runCycle(input int n, input int loadAt, input logic [DW-1:0] newOff,
                          input string tag);
    int nEff;
    longint sum, q, expV;
    bit expOvf, early;
    nEff = (n == 0) ? 1 : n;
    cycleCount = CW'(n);
    sum = 0;
    for (int i = 0; i < nEff; i++) begin
      sampleValid = 1'b1; sampleData = smp[i];
      if (i == loadAt) begin offLoad = 1'b1; offValue = newOff; end
      sum += sx(smp[i]) + offModel;
      @(posedge clk); @(negedge clk);
      if (i == loadAt) begin offLoad = 1'b0; offModel = sx(newOff); end
      sampleValid = 1'b0;
      sampleData = ~smp[i] ^ 24'h5A5A5A;  // garbage while invalid (R9)
      if (i < nEff - 1) begin @(posedge clk); @(negedge clk); end
    end
    q = sum / nEff;
    if ((sum % nEff) != 0 && sum < 0) q = q - 1;
    expOvf = 0; expV = q;
    if (q > MAXV) begin expV = MAXV; expOvf = 1; end
    if (q < MINV) begin expV = MINV; expOvf = 1; end
    early = cycleDone;
    for (int k = 1; k < LAT; k++) begin
      @(posedge clk); @(negedge clk);
      if (cycleDone) early = 1;
    end
    @(posedge clk); @(negedge clk);
    check(!early && cycleDone, {tag, " R6 done timing"}, longint'(cycleDone), 1);
    check(sx(activePower) == expV, {tag, expOvf ? " R5 value" : " R4 R9 value"},
          sx(activePower), expV);
    check(overflow == expOvf, {tag, " R5 flag"}, longint'(overflow), longint'(expOvf));
    @(posedge clk); @(negedge clk);
    check(!cycleDone && sx(activePower) == expV, {tag, " R6 hold"}, sx(activePower), expV);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(activePower == '0 && !overflow && !cycleDone, "R1 in reset", sx(activePower), 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check(activePower == '0 && !overflow && !cycleDone, "R1 after reset", sx(activePower), 0);

    // R1: offset resets to zero
    smp[0] = 24'd5;
    runCycle(1, -1, '0, "R1 offset reset");

    // R8: floor rounding
    smp[0] = 24'hFFFFFF; smp[1] = 24'h000000;
    runCycle(2, -1, '0, "R8 -1/2");
    smp[0] = 24'hFFFFFE; smp[1] = 24'hFFFFFF; smp[2] = 24'hFFFFFF;
    runCycle(3, -1, '0, "R8 -4/3");

    // R3: count of zero acts as one
    smp[0] = 24'h123456;
    runCycle(0, -1, '0, "R3 N=0");

    // R2: load together with the first sample; that sample uses old offset
    smp[0] = 24'h000100; smp[1] = 24'h000200;
    runCycle(2, 0, 24'd100, "R2 same-edge load");
    loadOffset('0);

    // R7: extreme sums over the largest N do not wrap
    loadOffset(24'h7FFFFF);
    for (int i = 0; i < 16; i++) smp[i] = 24'h7FFFFF;
    runCycle(15, -1, '0, "R7 max sum");
    loadOffset(24'h800000);
    for (int i = 0; i < 16; i++) smp[i] = 24'h800000;
    runCycle(15, -1, '0, "R7 min sum");

    // Sweep: offsets x patterns x every N (R3 R4 R5 R9)
    for (int o = 0; o < 5; o++) begin
      case (o)
        0: loadOffset(24'h000000);
        1: loadOffset(24'h7FFFFF);
        2: loadOffset(24'h800000);
        3: loadOffset(24'h000123);
        default: loadOffset(24'hFFF000);
      endcase
      for (int p = 0; p < 5; p++) begin
        for (int n = 0; n < 16; n++) begin
          for (int i = 0; i < 16; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            case (p)
              0: smp[i] = 24'h7FFFFF;
              1: smp[i] = 24'h800000;
              2: smp[i] = (i % 2 == 0) ? 24'h7FFFFF : 24'h800000;
              3: smp[i] = DW'(i * 32'h123457 - 32'h400000);
              default: smp[i] = lfsr[DW-1:0];
            endcase
          end
          runCycle(n, -1, '0, "R3 sweep");
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule